// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block holds the burst and latency settings of an SDRAM device and turns each read or write command into the column addresses of its burst. A mode word arrives on the address and bank lines with a load strobe. It is checked field by field. A legal word replaces the stored settings. A word with a reserved code raises an error flag and leaves the settings as they were. The stored CAS latency and the single-write mode are reported on plain status pins.

A command pulse carries a start column. One cycle later the block begins to emit column addresses on a valid/ready stream, one per accepted transfer. Bursts of 1, 2, 4 or 8 beats step through an aligned block in either wrap-around (sequential) or XOR (interleaved) order. The column bits above that block stay at their start value. A full-page burst walks all 512 columns, wrapping back to 0, until a stop pulse ends it. A stop pulse ends a burst of any length.

Back-pressure rules: an address is transferred in a cycle where `col_valid` and `col_ready` are both high. While `col_ready` is low, the address, `col_last` and `col_valid` hold. A stop or a new command still takes effect regardless of `col_ready`. The downstream side may hold `col_ready` low for any number of cycles.

Top module: `sdram_burst_ctrl`

## Requirements
- R1: A load with `mrs_bank`=00 and a legal word updates the stored settings, which take effect in the next cycle. The word fields are as follows. Bits 2:0 give the length: 000=1, 001=2, 010=4, 011=8, 111=full page. Bit 3 gives the order: 0 is sequential, 1 is interleaved. Bits 6:4 give the CAS latency: 001, 010 and 011 give 1, 2 and 3, which are reported on `cas_latency`. Bit 9 sets single-write mode, reported on `wr_single`.
- R2: A load is reserved in any of these cases: length code 100, 101 or 110; length code 111 with bit 3 set; latency code outside 001..011; bits 8:7 not 00; bits 12:10 not 0; `mrs_bank` 01 or 11. A reserved load sets `cfg_error` in the next cycle and leaves all settings unchanged. A legal normal load clears `cfg_error`. A load with `mrs_bank`=10 (extended register) changes neither the settings nor `cfg_error`.
- R3: After reset the settings are length 1, sequential, CAS latency 3 and single-write off, with `cfg_error` low and `col_valid` low.
- R4: In the cycle after `cmd_start`, `col_valid` is high and `col_addr` equals the `cmd_col` that came with the command.
- R5: In sequential order, beat i carries the low field (start + i) mod N, where N is the burst length. For N=4, a start of 2 gives 2,3,0,1.
- R6: In interleaved order, beat i carries the low field start XOR i. For N=8, a start of 5 gives 5,4,7,6,1,0,3,2.
- R7: A full-page burst steps through columns modulo 512 and never asserts `col_last`. It keeps going until a stop pulse arrives.
- R8: With single-write mode on, a write burst is one beat long, while a read burst uses the stored length.
- R9: `cmd_stop` drops `col_valid` in the next cycle. When `cmd_start` and `cmd_stop` arrive together, the new burst starts.
- R10: While `col_valid` is high and `col_ready` is low, `col_addr` and `col_valid` hold.
- R11: The column bits above the low log2(N) bits equal those of the start column on every beat.
- R12: `col_last` is high on the final beat of a finite burst. After that beat is transferred, `col_valid` is low.
- R13: A burst uses the settings in force at its command. A load during the burst does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_load | input | 1 | Mode word load strobe |
| mrs_bank | input | 2 | Register select (00 normal, 10 extended) |
| mrs_addr | input | 13 | Mode word |
| cmd_start | input | 1 | Read/write command pulse |
| cmd_write | input | 1 | Command is a write |
| cmd_col | input | 9 | Start column |
| cmd_stop | input | 1 | Burst stop pulse |
| col_valid | output | 1 | Column address valid |
| col_ready | input | 1 | Downstream accepts column address |
| col_addr | output | 9 | Column address |
| col_last | output | 1 | Final beat of a finite burst |
| cas_latency | output | 2 | Stored CAS latency (1..3) |
| wr_single | output | 1 | Single-write mode on |
| cfg_error | output | 1 | Last normal or invalid load was reserved |

## Verification
The bench targets three groups of corner cases.

- Wrap points: the sequential wrap inside an aligned block, the XOR sequence from an odd start, and the full-page rollover from 511 to 0. A design that adds without masking would carry into the upper column bits. A design that confuses the two orders would emit the other sequence.
- Mode loads: each reserved field is loaded on its own, and a burst is run afterwards. A design that commits part of a bad word would show a changed latency or burst length. A load is also made in the middle of a burst. A design that reads the live settings would cut that burst short.
- Stream control: single-write mode, back-pressure pauses, and a start and stop arriving together. A faulty design would emit four write beats, step past a stalled address, or drop the new burst.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} order_e;

  typedef struct packed {
    logic [2:0] len_code;
    order_e     order;
    logic [1:0] cl;
    logic       wr_single;
  } mode_t;

  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;

  localparam mode_t MODE_RESET = '{len_code: LEN_1, order: ORD_SEQ, cl: 2'd3, wr_single: 1'b0};

endpackage

// File: rtl/sdram_mode_decode.sv
module sdram_mode_decode
  import sdram_mode_pkg::*;
#(
  parameter int MODE_W = 13
) (
  input  logic [MODE_W-1:0] word_i,
  input  logic [1:0]        bank_i,
  output mode_t             mode_o,
  output logic              accept_o,
  output logic              reserved_o
);
  localparam int RFU_LSB = 10;

  logic [2:0] len_f;
  logic       ord_f;
  logic [2:0] cl_f;
  logic [1:0] opm_f;
  logic       rfu_nz;
  logic       len_bad, cl_bad, sel_norm, sel_ext;

  assign len_f  = word_i[2:0];
  assign ord_f  = word_i[3];
  assign cl_f   = word_i[6:4];
  assign opm_f  = word_i[8:7];
  assign rfu_nz = |word_i[MODE_W-1:RFU_LSB];

  always_comb begin
    len_bad  = (len_f inside {3'b100, 3'b101, 3'b110}) || ((len_f == LEN_PAGE) && ord_f);
    cl_bad   = !(cl_f inside {3'b001, 3'b010, 3'b011});
    sel_norm = (bank_i == 2'b00);
    sel_ext  = (bank_i == 2'b10);
    reserved_o = !(sel_norm || sel_ext) ||
                 (sel_norm && (len_bad || cl_bad || (opm_f != 2'b00) || rfu_nz));
    accept_o = sel_norm && !reserved_o;
    mode_o.len_code  = len_f;
    mode_o.order     = order_e'(ord_f);
    mode_o.cl        = cl_f[1:0];
    mode_o.wr_single = word_i[9];
  end
endmodule

// File: rtl/sdram_mode_store.sv
module sdram_mode_store
  import sdram_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  accept_i,
  input  logic  reserved_i,
  input  mode_t next_i,
  output mode_t mode_o,
  output logic  err_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= MODE_RESET;
      err_o  <= 1'b0;
    end else if (load_i) begin
      if (accept_i) begin
        mode_o <= next_i;
        err_o  <= 1'b0;
      end else if (reserved_i) begin
        err_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_mode_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode_i,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             stop_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [COL_W-1:0] addr_o,
  output logic             last_o
);
  logic [COL_W-1:0] base_q, mask_q, cnt_q, mask_d, low_sum;
  order_e           ord_q;
  logic             full_q, full_d, active_q;

  always_comb begin
    full_d = 1'b0;
    mask_d = '0;
    unique case (mode_i.len_code)
      LEN_2:    mask_d = COL_W'(1);
      LEN_4:    mask_d = COL_W'(3);
      LEN_8:    mask_d = COL_W'(7);
      LEN_PAGE: begin mask_d = '1; full_d = 1'b1; end
      default:  mask_d = '0;
    endcase
    if (write_i && mode_i.wr_single) begin
      mask_d = '0;
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
      ord_q    <= ORD_SEQ;
      full_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      base_q   <= col_i;
      mask_q   <= mask_d;
      cnt_q    <= '0;
      ord_q    <= mode_i.order;
      full_q   <= full_d;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q && ready_i) begin
      if (last_o) active_q <= 1'b0;
      else        cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign low_sum = (ord_q == ORD_XOR) ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign addr_o  = (base_q & ~mask_q) | (low_sum & mask_q);
  assign valid_o = active_q;
  assign last_o  = active_q && !full_q && (cnt_q == mask_q);
endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_mode_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_load,
  input  logic [1:0]        mrs_bank,
  input  logic [MODE_W-1:0] mrs_addr,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_stop,
  output logic              col_valid,
  input  logic              col_ready,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_last,
  output logic [1:0]        cas_latency,
  output logic              wr_single,
  output logic              cfg_error
);
  mode_t dec_mode, cur_mode;
  logic  dec_accept, dec_reserved;

  sdram_mode_decode #(.MODE_W(MODE_W)) u_dec (
    .word_i     (mrs_addr),
    .bank_i     (mrs_bank),
    .mode_o     (dec_mode),
    .accept_o   (dec_accept),
    .reserved_o (dec_reserved)
  );

  sdram_mode_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (mrs_load),
    .accept_i   (dec_accept),
    .reserved_i (dec_reserved),
    .next_i     (dec_mode),
    .mode_o     (cur_mode),
    .err_o      (cfg_error)
  );

  sdram_col_seq #(.COL_W(COL_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (cur_mode),
    .start_i (cmd_start),
    .write_i (cmd_write),
    .col_i   (cmd_col),
    .stop_i  (cmd_stop),
    .ready_i (col_ready),
    .valid_o (col_valid),
    .addr_o  (col_addr),
    .last_o  (col_last)
  );

  assign cas_latency = cur_mode.cl;
  assign wr_single   = cur_mode.wr_single;
endmodule

// File: rtl/sdram_burst_ctrl_chk.sv
module sdram_burst_ctrl_chk #(
  parameter int COL_W  = 9,
  parameter int MODE_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrs_load,
  input logic [1:0]       mrs_bank,
  input logic             cmd_start,
  input logic [COL_W-1:0] cmd_col,
  input logic             cmd_stop,
  input logic             col_valid,
  input logic             col_ready,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic [1:0]       cas_latency,
  input logic             wr_single,
  input logic             cfg_error
);
  AST_START_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> col_valid && (col_addr == $past(cmd_col))); // R4

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop && !cmd_start |=> !col_valid); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready && !cmd_start && !cmd_stop |=> col_valid && $stable(col_addr)); // R10

  AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_ready && col_last && !cmd_start |=> !col_valid); // R12

  AST_BAD_BANK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_load && mrs_bank[0] |=> cfg_error && $stable(cas_latency) && $stable(wr_single)); // R2

  AST_CL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cas_latency != 2'd0); // R1
endmodule

bind sdram_burst_ctrl sdram_burst_ctrl_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mrs_load    (mrs_load),
  .mrs_bank    (mrs_bank),
  .cmd_start   (cmd_start),
  .cmd_col     (cmd_col),
  .cmd_stop    (cmd_stop),
  .col_valid   (col_valid),
  .col_ready   (col_ready),
  .col_addr    (col_addr),
  .col_last    (col_last),
  .cas_latency (cas_latency),
  .wr_single   (wr_single),
  .cfg_error   (cfg_error)
);

// File: tb/sdram_burst_ctrl_test.sv
module sdram_burst_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrs_load = 1'b0;
  logic [1:0]  mrs_bank = 2'b00;
  logic [12:0] mrs_addr = '0;
  logic        cmd_start = 1'b0;
  logic        cmd_write = 1'b0;
  logic [8:0]  cmd_col = '0;
  logic        cmd_stop = 1'b0;
  logic        col_ready = 1'b1;
  logic        col_valid, col_last, wr_single, cfg_error;
  logic [8:0]  col_addr;
  logic [1:0]  cas_latency;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_burst_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mrs_load(mrs_load), .mrs_bank(mrs_bank), .mrs_addr(mrs_addr),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_col(cmd_col), .cmd_stop(cmd_stop),
    .col_valid(col_valid), .col_ready(col_ready), .col_addr(col_addr), .col_last(col_last),
    .cas_latency(cas_latency), .wr_single(wr_single), .cfg_error(cfg_error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_col(input logic [8:0] s, input int i, input int len, input bit x);
    logic [8:0] m, lo;
    m  = 9'(len - 1);
    lo = x ? (s ^ 9'(i)) : (s + 9'(i));
    return (s & ~m) | (lo & m);
  endfunction

  task automatic load(input logic [12:0] w, input logic [1:0] b);
    @(negedge clk);
    mrs_load = 1'b1; mrs_addr = w; mrs_bank = b;
    @(negedge clk);
    mrs_load = 1'b0;
  endtask

  // Issue a command and follow every beat; full bursts are stopped after nb beats.
  task automatic burst(input logic [8:0] s, input bit wr, input int len, input bit x,
                       input bit full, input int nb, input string req);
    @(negedge clk);
    cmd_start = 1'b1; cmd_write = wr; cmd_col = s;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int i = 0; i < nb; i++) begin
      chk(col_valid === 1'b1, req, col_valid, 1);
      chk(col_addr === exp_col(s, i, len, x), req, col_addr, exp_col(s, i, len, x));
      chk(col_last === (!full && i == nb - 1), req, col_last, (!full && i == nb - 1));
      if (full && i == nb - 1) cmd_stop = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0;
    end
    chk(col_valid === 1'b0, req, col_valid, 0);
  endtask

  task automatic t_reset();
    chk(cas_latency === 2'd3, "R3", cas_latency, 3);
    chk(wr_single === 1'b0, "R3", wr_single, 0);
    chk(cfg_error === 1'b0, "R3", cfg_error, 0);
    chk(col_valid === 1'b0, "R3", col_valid, 0);
    burst(9'h0F3, 1'b0, 1, 1'b0, 1'b0, 1, "R3");
  endtask

  task automatic t_sequential();
    load(13'h022, 2'b00);
    chk(cas_latency === 2'd2, "R1", cas_latency, 2);
    chk(cfg_error === 1'b0, "R1", cfg_error, 0);
    burst(9'h1A6, 1'b0, 4, 1'b0, 1'b0, 4, "R5 R11 R12");
    load(13'h011, 2'b00);
    chk(cas_latency === 2'd1, "R1", cas_latency, 1);
    burst(9'h0C9, 1'b1, 2, 1'b0, 1'b0, 2, "R5");
  endtask

  task automatic t_interleave();
    load(13'h01B, 2'b00);
    burst(9'h0F5, 1'b0, 8, 1'b1, 1'b0, 8, "R6 R11");
    load(13'h02A, 2'b00);
    burst(9'h133, 1'b0, 4, 1'b1, 1'b0, 4, "R6");
  endtask

  task automatic t_full_page();
    load(13'h037, 2'b00);
    burst(9'h1FE, 1'b0, 512, 1'b0, 1'b1, 6, "R7 R9");
  endtask

  task automatic t_reserved();
    load(13'h022, 2'b00);
    load(13'h034, 2'b00);
    chk(cfg_error === 1'b1, "R2 len code", cfg_error, 1);
    load(13'h03F, 2'b00);
    chk(cfg_error === 1'b1, "R2 page+xor", cfg_error, 1);
    load(13'h002, 2'b00);
    chk(cas_latency === 2'd2, "R2 cl code", cas_latency, 2);
    load(13'h1A2, 2'b00);
    chk(cfg_error === 1'b1, "R2 mode bits", cfg_error, 1);
    load(13'h0432, 2'b00);
    chk(cfg_error === 1'b1, "R2 rfu bits", cfg_error, 1);
    load(13'h033, 2'b01);
    chk(cas_latency === 2'd2, "R2 bank", cas_latency, 2);
    burst(9'h041, 1'b0, 4, 1'b0, 1'b0, 4, "R2 length kept");
    load(13'h031, 2'b10);
    chk(cas_latency === 2'd2, "R2 ext", cas_latency, 2);
    chk(cfg_error === 1'b1, "R2 ext", cfg_error, 1);
    load(13'h033, 2'b00);
    chk(cfg_error === 1'b0, "R2 clear", cfg_error, 0);
    chk(cas_latency === 2'd3, "R1", cas_latency, 3);
    burst(9'h00A, 1'b0, 8, 1'b0, 1'b0, 8, "R1 R5");
  endtask

  task automatic t_single_write();
    load(13'h222, 2'b00);
    chk(wr_single === 1'b1, "R8", wr_single, 1);
    burst(9'h055, 1'b1, 1, 1'b0, 1'b0, 1, "R8 write");
    burst(9'h055, 1'b0, 4, 1'b0, 1'b0, 4, "R8 read");
  endtask

  task automatic t_backpressure();
    load(13'h022, 2'b00);
    @(negedge clk);
    cmd_start = 1'b1; cmd_write = 1'b0; cmd_col = 9'h00A;
    @(negedge clk);
    cmd_start = 1'b0;
    col_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(col_valid === 1'b1 && col_addr === 9'h00A, "R10", col_addr, 9'h00A);
      @(negedge clk);
    end
    col_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(col_addr === exp_col(9'h00A, i, 4, 1'b0), "R10", col_addr, exp_col(9'h00A, i, 4, 1'b0));
      @(negedge clk);
    end
    chk(col_valid === 1'b0, "R10 R12", col_valid, 0);
  endtask

  task automatic t_latch();
    @(negedge clk);
    cmd_start = 1'b1; cmd_write = 1'b0; cmd_col = 9'h010;
    @(negedge clk);
    cmd_start = 1'b0;
    mrs_load = 1'b1; mrs_addr = 13'h020; mrs_bank = 2'b00;
    for (int i = 0; i < 4; i++) begin
      chk(col_valid === 1'b1 && col_addr === exp_col(9'h010, i, 4, 1'b0), "R13",
          col_addr, exp_col(9'h010, i, 4, 1'b0));
      @(negedge clk);
      mrs_load = 1'b0;
    end
    chk(col_valid === 1'b0, "R13", col_valid, 0);
    burst(9'h077, 1'b0, 1, 1'b0, 1'b0, 1, "R13 new length");
  endtask

  task automatic t_start_and_stop();
    load(13'h022, 2'b00);
    @(negedge clk);
    cmd_start = 1'b1; cmd_col = 9'h000;
    @(negedge clk);
    cmd_start = 1'b1; cmd_stop = 1'b1; cmd_col = 9'h102;
    @(negedge clk);
    cmd_start = 1'b0; cmd_stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(col_valid === 1'b1 && col_addr === exp_col(9'h102, i, 4, 1'b0), "R9 start wins",
          col_addr, exp_col(9'h102, i, 4, 1'b0));
      @(negedge clk);
    end
    chk(col_valid === 1'b0, "R9", col_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_interleave();
    t_full_page();
    t_reserved();
    t_single_write();
    t_backpressure();
    t_latch();
    t_start_and_stop();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule